// File: doc/BRIEF.md
# GPIO Edge-Sense Interrupt Controller

This block turns activity on a 16-line general-purpose input port into a single interrupt request. Each line carries a two-bit edge selector that picks rising edges, falling edges, both, or nothing, plus a mask bit. Pin levels are brought into the clock domain through a two-flop synchronizer. An edge is found by comparing the synchronized level with the level one cycle earlier. Each qualifying edge on an unmasked line latches a sticky bit in a source register.

The interrupt output is active low and is driven low while any pending source bit belongs to an unmasked line. Its only states are released (high) and pulled low, which suits a wired, shared request line. Software services the block through a small register port. Writes take effect on the clock edge and reads return data combinationally. Pending bits are cleared by writing ones to them. A read of the pin-level register can also clear them all, unless a control bit keeps them.

Register addresses: 0 holds the mask (bits 15:0), 1 holds the sense word (bits 31:0), 2 holds the source bits (bits 15:0), 3 holds the control bit (bit 0) and 4 reads the synchronized pin levels (bits 15:0). Reads of any other address return zero.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the mask register reads 0x0000FFFF, the sense, source and control registers read 0, and irq_n is high.
- R2: The edge selector of line n occupies sense bits [2n+1:2n]. Code 01 captures rising edges, 10 captures falling edges, 11 captures both and 00 captures none.
- R3: A change on pin_in becomes visible in the source register on the third rising clock edge after the change, and not earlier.
- R4: A line whose mask bit is 1 never sets its source bit, whatever its sense code.
- R5: Setting a mask bit leaves an already pending source bit unchanged; only the interrupt output reflects the mask.
- R6: Writing address 2 clears every source bit whose written bit is 1 and leaves every bit written as 0 unchanged.
- R7: When an unmasked edge on a line coincides with a clearing write to that line's source bit, the bit stays set.
- R8: irq_n is low exactly while some source bit is 1 and its mask bit is 0.
- R9: With control bit 0 at 0, reading address 4 clears all source bits on that clock edge; with control bit 0 at 1 such a read leaves them unchanged.
- R10: Address 4 reads the synchronized pin levels in bits 15:0.
- R11: A steady pin level never sets a source bit; only a change of level does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 16 | Asynchronous pin levels |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (side effect only on address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A wrong source bit appears at the ports in two ways. If the bit's line is unmasked, irq_n shows it in the same cycle. In every case a read of address 2 shows it in the next cycle. A defect in the synchronizer or edge detector shows up as an event one cycle early or late, or on the wrong polarity. The bench checks this at the exact cycle where a source bit must still be clear and the cycle where it must be set. Faults in clearing, in the priority between an edge and a clear, and in masking all leave a stale or missing bit. The next read of the source register shows it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    ADDR_MASK  = 3'd0,
    ADDR_SENSE = 3'd1,
    ADDR_SRC   = 3'd2,
    ADDR_CTRL  = 3'd3,
    ADDR_LEVEL = 3'd4
  } reg_addr_e;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;

  // code bit 0 enables low-to-high, code bit 1 enables high-to-low
  function automatic logic edge_hit(input logic [1:0] code, input logic prev, input logic cur);
    return (code[0] & ~prev & cur) | (code[1] & prev & ~cur);
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_in,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] level_prev
);
  logic [LINES-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= pin_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_prev <= '0;
    else        level_prev <= stage_q[STAGES-1];

  assign level = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES = 16
) (
  input  logic [LINES-1:0]   level,
  input  logic [LINES-1:0]   level_prev,
  input  logic [2*LINES-1:0] sense,
  output logic [LINES-1:0]   hit
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hit[i] = edge_hit(sense[2*i+1 -: 2], level_prev[i], level[i]);
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [LINES-1:0]   hit,
  input  logic [LINES-1:0]   level,
  output logic [REG_W-1:0]   rdata,
  output logic [LINES-1:0]   mask,
  output logic [2*LINES-1:0] sense,
  output logic [LINES-1:0]   src
);
  logic keep_q;

  // named internal events for the checks below
  logic [LINES-1:0] set_vec;
  logic [LINES-1:0] clr_vec;
  logic             rd_clear;

  assign set_vec  = hit & ~mask;
  assign rd_clear = rd_en && (addr == ADDR_LEVEL) && !keep_q;
  assign clr_vec  = ((wr_en && addr == ADDR_SRC) ? wdata[LINES-1:0] : '0)
                  | {LINES{rd_clear}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '1;
      sense  <= '0;
      keep_q <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        ADDR_MASK:  mask   <= wdata[LINES-1:0];
        ADDR_SENSE: sense  <= wdata[2*LINES-1:0];
        ADDR_CTRL:  keep_q <= wdata[0];
        default:    ;
      endcase
    end
  end

  // a fresh edge overrides a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src <= '0;
    else        src <= (src & ~clr_vec) | set_vec;

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      ADDR_MASK:  rdata[LINES-1:0]   = mask;
      ADDR_SENSE: rdata[2*LINES-1:0] = sense;
      ADDR_SRC:   rdata[LINES-1:0]   = src;
      ADDR_CTRL:  rdata[0]           = keep_q;
      ADDR_LEVEL: rdata[LINES-1:0]   = level;
      default:    rdata = '0;
    endcase
  end

  // R4: a bit rises only after an unmasked edge
  assert_set_only_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((src & ~$past(src) & ~$past(set_vec)) == '0));

  // R6, R9: a requested clear without an edge removes the bit
  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr_vec & ~set_vec) & src) == '0));

  // R7: every unmasked edge is latched, clear or not
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_vec) & ~src) == '0));

  // R5: pending bits vanish only through a clear request
  assert_no_stray_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(src) & ~$past(clr_vec) & ~src) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINES-1:0]    pin_in,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                irq_n
);
  localparam int unsigned SENSE_W = 2 * LINES;

  logic [LINES-1:0]   level;
  logic [LINES-1:0]   level_prev;
  logic [LINES-1:0]   hit;
  logic [LINES-1:0]   mask;
  logic [LINES-1:0]   src;
  logic [SENSE_W-1:0] sense;
  logic               mask_wr;

  gpio_irq_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .level(level), .level_prev(level_prev)
  );

  gpio_irq_detect #(.LINES(LINES)) detect_i (
    .level(level), .level_prev(level_prev), .sense(sense), .hit(hit)
  );

  gpio_irq_regs #(.LINES(LINES)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .hit(hit), .level(level),
    .rdata(reg_rdata), .mask(mask), .sense(sense), .src(src)
  );

  assign mask_wr = reg_wr_en && (reg_addr == ADDR_MASK);
  assign irq_n   = ~|(src & ~mask);

  // R8: the request only drops after an unmasked edge or a mask change
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(|(hit & ~mask)) || $past(mask_wr)));
endmodule

// File: tb/gpio_edge_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_in = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_n;
  logic        irq_probe = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;   // 250 MHz

  gpio_edge_irq dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // monitor: compares mid-cycle, away from the rising edge
  always @(negedge clk) begin
    if (reg_rd_en || irq_probe) begin
      logic [31:0] act;
      act = irq_probe ? {31'b0, irq_n} : reg_rdata;
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: got %h expected nothing", act);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    reg_rd_en = 1'b1; reg_addr = a;
    tick();
    reg_rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string req);
    item_t it;
    it.exp = {31'b0, e}; it.req = req;
    sb_q.push_back(it);
    irq_probe = 1'b1;
    tick();
    irq_probe = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(3'd0, 32'h0000FFFF, "R1 mask");
    rd(3'd1, 32'h0, "R1 sense");
    rd(3'd2, 32'h0, "R1 source");
    rd(3'd3, 32'h0, "R1 ctrl");
    chk_irq(1'b1, "R1 irq_n");

    // R2 line0 rise, line1 fall, line2/3 both, line4 none, line5 rise but masked
    wr(3'd1, 32'h000004F9);
    wr(3'd0, 32'h0000FFE0);
    rd(3'd1, 32'h000004F9, "R2 sense readback");

    // R3 timing: visible on third edge after the change
    pin_in = 16'h0037;
    tick(); tick();
    rd(3'd2, 32'h0, "R3 not yet");
    rd(3'd2, 32'h00000005, "R2 R4 R3 rise capture");
    chk_irq(1'b0, "R8 pending unmasked");

    // R6 write-one-to-clear
    wr(3'd2, 32'h00000001);
    rd(3'd2, 32'h00000004, "R6 clear bit0");
    wr(3'd2, 32'h00000000);
    rd(3'd2, 32'h00000004, "R6 zero write keeps");

    // R11 held level does not re-trigger
    repeat (3) tick();
    rd(3'd2, 32'h00000004, "R11 level ignored");

    // R5 masking keeps pending bit
    wr(3'd0, 32'h0000FFE4);
    rd(3'd2, 32'h00000004, "R5 masked pending kept");
    chk_irq(1'b1, "R8 masked pending");
    wr(3'd0, 32'h0000FFE0);
    chk_irq(1'b0, "R8 unmasked again");
    wr(3'd2, 32'h00000004);
    chk_irq(1'b1, "R8 after clear");

    // R2 falling edges
    pin_in = 16'h0030;
    repeat (3) tick();
    rd(3'd2, 32'h00000006, "R2 fall capture");

    // R7 edge coincides with clear
    pin_in = 16'h0038;
    tick(); tick();
    wr(3'd2, 32'h0000000A);
    rd(3'd2, 32'h0000000C, "R7 edge wins");

    // R10 and R9 auto-clear on level read
    rd(3'd4, 32'h00000038, "R10 levels");
    rd(3'd2, 32'h0, "R9 auto-clear");

    // R9 keep when control bit set
    wr(3'd3, 32'h00000001);
    rd(3'd3, 32'h00000001, "R9 ctrl readback");
    pin_in = 16'h0030;
    repeat (3) tick();
    rd(3'd2, 32'h00000008, "R9 event");
    rd(3'd4, 32'h00000030, "R10 levels 2");
    rd(3'd2, 32'h00000008, "R9 kept on read");

    tick();
    finish_run();
  end
endmodule